// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block folds sixteen serial-interrupt request levels and nine host-controller event levels into a single level interrupt. Collection happens in two stages. The first stage is the host-controller stage. Each request or event input that is high on a clock edge sets its own sticky bit in a status word. A mask selects which status bits count, and a global enable in the frame-control register gates the whole stage. The one combined line that results is the only live bit of the input word of the second stage, the bus-master stage. The bus-master stage ORs its masked input into a sticky status word on every clock. The final interrupt is registered from "bus-master status is nonzero".

Software reaches both stages through one 32-bit register port. `bus_sel` picks the stage and `bus_off` picks the byte offset inside that stage. Every access is a full word, so byte lanes never arise. Bit 31 is the most significant bit of each word. Both status words are write-one-to-clear, so only software can clear them. The frame-control register also carries the quiet-mode bit and the start-frame length code for the serial-frame engine that sits next to this block. The block decodes both and drives them out.

Top module: `irq_two_level_agg`

## Requirements
- R1: After reset, both status words, both masks, the frame-control register and `irq_out` are zero, and the host-stage firmware read-size register (offset 0x28) reads 0x02000000.
- R2: Request input `req_lvl[n]` high on a clock edge sets host status bit 31-n (offset 0x38, bits 31 down to 16). The bit is visible after that edge, and a later low level leaves it set.
- R3: Event input `ctl_evt[8]` sets host status bit 10. Event inputs `ctl_evt[7:0]` set host status bits 7 to 0, with the same index.
- R4: A write to host status (offset 0x38) clears each bit written as 1 and leaves the others unchanged. A bit whose input is still high is set again on the same edge.
- R5: The host-stage line is high exactly when frame-control bit 31 (enable) is set and host status AND host mask (offset 0x34) is nonzero. The line reads back as bit 11 (0x800) of the bus-master input word (bus-master offset 0x5C) with no added delay.
- R6: The bus-master input word is read-only: writes to it are ignored, and every bit other than bit 11 reads 0.
- R7: On every clock, bus-master status (offset 0x50) takes on its previous value OR (input AND bus-master mask at offset 0x54). Bus-master status bits stay set after the input drops and clear only when written as 1.
- R8: `irq_out` goes high or low one clock after bus-master status becomes nonzero or zero.
- R9: Bus-master polarity (0x58) has no effect on `irq_out`. The bus-master route registers (0x08, 0x0C), the polarity register, and the host firmware segment (0x24) and read-size (0x28) registers all read back the last word written.
- R10: The host error-address register (0x40) reads 0 and ignores writes. A read of any unimplemented offset in either stage returns 0xFFFFFFFF, and writes to those offsets change nothing.
- R11: `frame_quiet` follows frame-control bit 30. `frame_start_clks` is 4, 6 or 8 for frame-control bits 25:24 equal to 0, 1 or 2, and 8 for code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Stage select: 0 host stage, 1 bus-master stage |
| bus_off | input | 8 | Byte offset inside the selected stage |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_sel`/`bus_off`, combinational |
| req_lvl | input | 16 | Serial-interrupt request levels, line n in bit n |
| ctl_evt | input | 9 | Host event levels (link reset and sync/turnaround/request events) |
| frame_quiet | output | 1 | Quiet-mode selection for the frame engine |
| frame_start_clks | output | 4 | Start-frame length in clocks |
| irq_out | output | 1 | Registered aggregated interrupt |

## Verification
The bench drives single-cycle pulses on the first and last request lines and on the edge event bits. The readback values then show the bit reversal of the request lines and the gap in the event mapping. A pulse with the enable clear, and then with the enable set, separates the gate from the mask. The host status is cleared while the bus-master bit is still held, which tells stickiness in the second stage apart from simple pass-through. Clearing an event while its source is still high shows that the set term wins over the clear. Writes to the read-only, unimplemented and error-address offsets are each followed by a readback, and a polarity write is followed by a look at `irq_out`, so that a stray side effect would show at the ports.

// File: rtl/irqagg_pkg.sv
// Shared constants for the two-level interrupt aggregator.
// Assumes 32-bit words and byte offsets that fit in OFF_W bits.
package irqagg_pkg;
    localparam int DW    = 32;
    localparam int OFF_W = 8;

    // host-controller stage offsets
    localparam logic [OFF_W-1:0] C_SEGSEL = 8'h24;
    localparam logic [OFF_W-1:0] C_ACCSZ  = 8'h28;
    localparam logic [OFF_W-1:0] C_FCTRL  = 8'h30;
    localparam logic [OFF_W-1:0] C_MASK   = 8'h34;
    localparam logic [OFF_W-1:0] C_STAT   = 8'h38;
    localparam logic [OFF_W-1:0] C_ERRADR = 8'h40;

    // bus-master stage offsets
    localparam logic [OFF_W-1:0] M_ROUTE0 = 8'h08;
    localparam logic [OFF_W-1:0] M_ROUTE1 = 8'h0C;
    localparam logic [OFF_W-1:0] M_STAT   = 8'h50;
    localparam logic [OFF_W-1:0] M_MASK   = 8'h54;
    localparam logic [OFF_W-1:0] M_POL    = 8'h58;
    localparam logic [OFF_W-1:0] M_INPUT  = 8'h5C;

    localparam logic [DW-1:0] ACCSZ_RST = 32'h0200_0000;
    localparam int LINE_BIT  = 11;  // host line position in master input
    localparam int EN_BIT    = 31;
    localparam int QUIET_BIT = 30;
    localparam int START_LO  = 24;
    localparam int NUM_EVT   = 9;

    // status bit position of host event input i
    function automatic int evt_pos(input int i);
        return (i == NUM_EVT - 1) ? 10 : i;
    endfunction
endpackage

// File: rtl/irqagg_ctl_stage.sv
// Host-controller stage: latches request and event levels into a sticky
// status word, applies a mask and a global enable, and produces one line.
// Assumes NUM_REQ request lines fill the status word from bit DW-1 down
// and do not overlap the event bits.
module irqagg_ctl_stage
    import irqagg_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   off,
    input  logic [DW-1:0]      wdata,
    input  logic [NUM_REQ-1:0] req_lvl,
    input  logic [NUM_EVT-1:0] evt,
    output logic [DW-1:0]      rdata,
    output logic               line_out,
    output logic [DW-1:0]      status_q,
    output logic [DW-1:0]      mask_q,
    output logic [DW-1:0]      fctrl_q
);
    logic [DW-1:0] segsel_q;
    logic [DW-1:0] accsz_q;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;

    // map request lines (reversed) and events onto status bit positions
    always_comb begin
        set_vec = '0;
        for (int n = 0; n < NUM_REQ; n++) set_vec[DW-1-n] = req_lvl[n];
        for (int i = 0; i < NUM_EVT; i++) set_vec[evt_pos(i)] = evt[i];
    end

    // write-one-to-clear pattern for this cycle
    assign clr_vec = (wr_en && off == C_STAT) ? wdata : '0;

    // register file and sticky status update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            fctrl_q  <= '0;
            segsel_q <= '0;
            accsz_q  <= ACCSZ_RST;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (wr_en) begin
                case (off)
                    C_MASK:   mask_q   <= wdata;
                    C_FCTRL:  fctrl_q  <= wdata;
                    C_SEGSEL: segsel_q <= wdata;
                    C_ACCSZ:  accsz_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // gated combine of masked status
    assign line_out = fctrl_q[EN_BIT] & (|(status_q & mask_q));

    // read decode; unknown offsets return all ones
    always_comb begin
        case (off)
            C_SEGSEL: rdata = segsel_q;
            C_ACCSZ:  rdata = accsz_q;
            C_FCTRL:  rdata = fctrl_q;
            C_MASK:   rdata = mask_q;
            C_STAT:   rdata = status_q;
            C_ERRADR: rdata = '0;
            default:  rdata = '1;
        endcase
    end
endmodule

// File: rtl/irqagg_master_stage.sv
// Bus-master stage: one live input bit (the host line), sticky status
// accumulating input AND mask every clock, and a registered interrupt.
// Assumes polarity and route words are storage only.
module irqagg_master_stage
    import irqagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    input  logic             line_in,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    status_q,
    output logic             irq_q
);
    logic [DW-1:0] route0_q;
    logic [DW-1:0] route1_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] pol_q;
    logic [DW-1:0] in_vec;
    logic [DW-1:0] clr_vec;

    // place the host line at its input position
    always_comb begin
        in_vec = '0;
        in_vec[LINE_BIT] = line_in;
    end

    // write-one-to-clear pattern for this cycle
    assign clr_vec = (wr_en && off == M_STAT) ? wdata : '0;

    // register file, sticky accumulation and registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route0_q <= '0;
            route1_q <= '0;
            mask_q   <= '0;
            pol_q    <= '0;
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= (status_q & ~clr_vec) | (in_vec & mask_q);
            irq_q    <= |status_q;
            if (wr_en) begin
                case (off)
                    M_ROUTE0: route0_q <= wdata;
                    M_ROUTE1: route1_q <= wdata;
                    M_MASK:   mask_q   <= wdata;
                    M_POL:    pol_q    <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // read decode; unknown offsets return all ones
    always_comb begin
        case (off)
            M_ROUTE0: rdata = route0_q;
            M_ROUTE1: rdata = route1_q;
            M_STAT:   rdata = status_q;
            M_MASK:   rdata = mask_q;
            M_POL:    rdata = pol_q;
            M_INPUT:  rdata = in_vec;
            default:  rdata = '1;
        endcase
    end
endmodule

// File: rtl/irq_two_level_agg.sv
// Top of the two-level interrupt aggregator: steers the register port to
// one of two stages, chains the host line into the bus-master stage and
// decodes the frame-control fields for the neighbouring frame engine.
// Assumes one full-word access per cycle and combinational read data.
module irq_two_level_agg
    import irqagg_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic [irqagg_pkg::OFF_W-1:0]    bus_off,
    input  logic                            bus_wr,
    input  logic [irqagg_pkg::DW-1:0]       bus_wdata,
    output logic [irqagg_pkg::DW-1:0]       bus_rdata,
    input  logic [NUM_REQ-1:0]              req_lvl,
    input  logic [irqagg_pkg::NUM_EVT-1:0]  ctl_evt,
    output logic                            frame_quiet,
    output logic [3:0]                      frame_start_clks,
    output logic                            irq_out
);
    logic [DW-1:0] c_rdata;
    logic [DW-1:0] m_rdata;
    logic [DW-1:0] ctl_status;
    logic [DW-1:0] ctl_mask;
    logic [DW-1:0] ctl_fctrl;
    logic [DW-1:0] m_status;
    logic          s1_line;

    irqagg_ctl_stage #(.NUM_REQ(NUM_REQ)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr & ~bus_sel),
        .off      (bus_off),
        .wdata    (bus_wdata),
        .req_lvl  (req_lvl),
        .evt      (ctl_evt),
        .rdata    (c_rdata),
        .line_out (s1_line),
        .status_q (ctl_status),
        .mask_q   (ctl_mask),
        .fctrl_q  (ctl_fctrl)
    );

    irqagg_master_stage u_mst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr & bus_sel),
        .off      (bus_off),
        .wdata    (bus_wdata),
        .line_in  (s1_line),
        .rdata    (m_rdata),
        .status_q (m_status),
        .irq_q    (irq_out)
    );

    // stage-selected read data
    assign bus_rdata = bus_sel ? m_rdata : c_rdata;

    // frame-control field decode for the frame engine
    assign frame_quiet = ctl_fctrl[QUIET_BIT];
    always_comb begin
        case (ctl_fctrl[START_LO+1:START_LO])
            2'd0:    frame_start_clks = 4'd4;
            2'd1:    frame_start_clks = 4'd6;
            default: frame_start_clks = 4'd8;
        endcase
    end
endmodule

// File: rtl/irq_two_level_agg_chk.sv
// Property checker for the aggregator, bound into every instance.
// Assumes it sees the top's ports and its inter-stage signals.
module irq_two_level_agg_chk
    import irqagg_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic [OFF_W-1:0]   bus_off,
    input logic               bus_wr,
    input logic [DW-1:0]      bus_rdata,
    input logic [NUM_REQ-1:0] req_lvl,
    input logic [3:0]         frame_start_clks,
    input logic               irq_out,
    input logic [DW-1:0]      ctl_status,
    input logic [DW-1:0]      ctl_mask,
    input logic [DW-1:0]      m_status,
    input logic               s1_line
);
    logic ctl_stat_wr;
    logic m_stat_wr;
    logic ctl_known;
    assign ctl_stat_wr = bus_wr && !bus_sel && bus_off == C_STAT;
    assign m_stat_wr   = bus_wr &&  bus_sel && bus_off == M_STAT;
    assign ctl_known   = bus_off inside {C_SEGSEL, C_ACCSZ, C_FCTRL, C_MASK, C_STAT, C_ERRADR};

    for (genvar n = 0; n < NUM_REQ; n++) begin : g_req
        assert_req_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            req_lvl[n] |=> ctl_status[DW-1-n]);
    end

    assert_ctl_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stat_wr |=> ((ctl_status & $past(ctl_status)) == $past(ctl_status)));

    assert_line_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_line |-> ((ctl_status & ctl_mask) != '0));

    assert_m_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !m_stat_wr |=> ((m_status & $past(m_status)) == $past(m_status)));

    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(m_stat_wr, 2));

    assert_unimpl_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !ctl_known) |-> (bus_rdata == '1));

    assert_start_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_clks == 4'd4) || (frame_start_clks == 4'd6) || (frame_start_clks == 4'd8));
endmodule

bind irq_two_level_agg irq_two_level_agg_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_sel          (bus_sel),
    .bus_off          (bus_off),
    .bus_wr           (bus_wr),
    .bus_rdata        (bus_rdata),
    .req_lvl          (req_lvl),
    .frame_start_clks (frame_start_clks),
    .irq_out          (irq_out),
    .ctl_status       (ctl_status),
    .ctl_mask         (ctl_mask),
    .m_status         (m_status),
    .s1_line          (s1_line)
);

// File: tb/irq_two_level_agg_test.sv
module irq_two_level_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_off = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] req_lvl = '0;
    logic [8:0]  ctl_evt = '0;
    logic        frame_quiet;
    logic [3:0]  frame_start_clks;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_two_level_agg uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_off(bus_off),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_lvl(req_lvl), .ctl_evt(ctl_evt), .frame_quiet(frame_quiet),
        .frame_start_clks(frame_start_clks), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    // one write; returns at the falling edge after the capturing edge
    task automatic wr(input logic sel, input logic [7:0] off, input logic [31:0] d);
        bus_sel = sel; bus_off = off; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] off, output logic [31:0] d);
        bus_sel = sel; bus_off = off; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, 8'h28, d); check("R1 read-size reset", d, 32'h0200_0000);
        rd(0, 8'h38, d); check("R1 host status reset", d, 0);
        rd(0, 8'h34, d); check("R1 host mask reset", d, 0);
        rd(0, 8'h30, d); check("R1 frame ctrl reset", d, 0);
        rd(1, 8'h50, d); check("R1 master status reset", d, 0);
        rd(1, 8'h54, d); check("R1 master mask reset", d, 0);
        check("R1 irq reset", {31'd0, irq_out}, 0);
    endtask

    task automatic t_requests;
        logic [31:0] d;
        req_lvl = 16'h0001; idle(1); req_lvl = 16'h0000; idle(1);
        rd(0, 8'h38, d); check("R2 line 0 -> bit 31, held after low", d, 32'h8000_0000);
        req_lvl = 16'h8000; idle(1); req_lvl = 0;
        rd(0, 8'h38, d); check("R2 line 15 -> bit 16", d, 32'h8001_0000);
        wr(0, 8'h38, 32'h8000_0000);
        rd(0, 8'h38, d); check("R4 clear only written ones", d, 32'h0001_0000);
        wr(0, 8'h38, 32'hFFFF_FFFF);
        rd(0, 8'h38, d); check("R4 clear all", d, 0);
    endtask

    task automatic t_events;
        logic [31:0] d;
        ctl_evt = 9'h100; idle(1); ctl_evt = 0;
        rd(0, 8'h38, d); check("R3 link-reset event -> bit 10", d, 32'h0000_0400);
        ctl_evt = 9'h081; idle(1);
        ctl_evt = 9'h001;
        rd(0, 8'h38, d); check("R3 events 7 and 0", d, 32'h0000_0481);
        wr(0, 8'h38, 32'h0000_0481);
        rd(0, 8'h38, d); check("R4 held source re-sets on clear", d, 32'h0000_0001);
        ctl_evt = 0;
        wr(0, 8'h38, 32'hFFFF_FFFF);
        rd(0, 8'h38, d); check("R4 cleared after source low", d, 0);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        wr(0, 8'h34, 32'h8000_0000);
        req_lvl = 16'h0001; idle(1); req_lvl = 0;
        rd(1, 8'h5C, d); check("R5 gated off without enable", d, 0);
        wr(0, 8'h30, 32'h8000_0000);
        rd(1, 8'h5C, d); check("R5 line on with enable", d, 32'h0000_0800);
        idle(2);
        rd(1, 8'h50, d); check("R7 unmasked input not latched", d, 0);
        check("R8 irq low while master status zero", {31'd0, irq_out}, 0);
        wr(1, 8'h54, 32'h0000_0800);
        idle(1);
        rd(1, 8'h50, d); check("R7 masked input latched", d, 32'h0000_0800);
        check("R8 irq one clock later, not yet", {31'd0, irq_out}, 0);
        idle(1);
        check("R8 irq high", {31'd0, irq_out}, 1);
        wr(0, 8'h38, 32'h8000_0000);
        rd(1, 8'h5C, d); check("R5 line drops with host status", d, 0);
        idle(2);
        rd(1, 8'h50, d); check("R7 master status sticky", d, 32'h0000_0800);
        check("R7 irq held", {31'd0, irq_out}, 1);
        wr(1, 8'h50, 32'h0000_0800);
        rd(1, 8'h50, d); check("R7 master write-one clears", d, 0);
        check("R8 irq still high one clock", {31'd0, irq_out}, 1);
        idle(1);
        check("R8 irq low", {31'd0, irq_out}, 0);
    endtask

    task automatic t_storage;
        logic [31:0] d;
        wr(1, 8'h58, 32'hFFFF_FFFF); idle(2);
        rd(1, 8'h58, d); check("R9 polarity readback", d, 32'hFFFF_FFFF);
        check("R9 polarity no effect on irq", {31'd0, irq_out}, 0);
        wr(1, 8'h08, 32'h1234_5678);
        wr(1, 8'h0C, 32'h9ABC_DEF0);
        rd(1, 8'h08, d); check("R9 route0", d, 32'h1234_5678);
        rd(1, 8'h0C, d); check("R9 route1", d, 32'h9ABC_DEF0);
        wr(0, 8'h24, 32'h0000_00A5);
        wr(0, 8'h28, 32'h0700_0000);
        rd(0, 8'h24, d); check("R9 segment select", d, 32'h0000_00A5);
        rd(0, 8'h28, d); check("R9 read size", d, 32'h0700_0000);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr(1, 8'h5C, 32'hFFFF_FFFF);
        rd(1, 8'h5C, d); check("R6 input ignores write", d, 0);
        wr(0, 8'h40, 32'hDEAD_BEEF);
        rd(0, 8'h40, d); check("R10 error address zero", d, 0);
        wr(0, 8'h10, 32'h0);
        wr(1, 8'h20, 32'h0);
        rd(0, 8'h10, d); check("R10 host unimplemented", d, 32'hFFFF_FFFF);
        rd(1, 8'h20, d); check("R10 master unimplemented", d, 32'hFFFF_FFFF);
        rd(0, 8'h24, d); check("R10 unimplemented write harmless", d, 32'h0000_00A5);
        rd(0, 8'h34, d); check("R10 mask untouched", d, 32'h8000_0000);
    endtask

    task automatic t_frame;
        wr(0, 8'h30, 32'h4000_0000);
        check("R11 quiet", {31'd0, frame_quiet}, 1);
        check("R11 code 0 -> 4", {28'd0, frame_start_clks}, 4);
        wr(0, 8'h30, 32'h0100_0000);
        check("R11 quiet off", {31'd0, frame_quiet}, 0);
        check("R11 code 1 -> 6", {28'd0, frame_start_clks}, 6);
        wr(0, 8'h30, 32'h0200_0000);
        check("R11 code 2 -> 8", {28'd0, frame_start_clks}, 8);
        wr(0, 8'h30, 32'h0300_0000);
        check("R11 code 3 -> 8", {28'd0, frame_start_clks}, 8);
    endtask

    initial begin
        #200_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_requests();
        t_events();
        t_chain();
        t_storage();
        t_readonly();
        t_frame();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule